// File: doc/BRIEF.md
# Synchronous Burst SRAM Core with Selectable Read Latency

This block is a synchronous static memory front end for on-chip use. Address, control and write data are captured on the rising clock edge into an access stage. The stage drives a small word-organised array split into 9-bit byte lanes, each lane including a parity bit. Reads come out on a data bus that has its own drive-enable signal, so the bus behaves like a tristate bus. A configuration input selects the read latency. In flow-through mode the array output goes straight to the bus. In pipelined mode a rising-edge output register adds one cycle.

Two address strobes can start an access. The host strobe always starts a read and checks only two of the three chip enables. The controller strobe checks all three chip enables and can start either a read or a write. While an access is open, an external burst sequencer supplies each next address, and an advance input either runs the next access or holds the bus. Turning the bus off uses dual cycle deselect: a deselect or write keeps the bus driven for one full cycle and stops driving it after the following edge, in either latency mode. An output-enable input and a sleep input gate the drivers without any clock. Sleep also blocks all accesses, and the array keeps its contents.

Top module: `sbsram_core`

## Requirements
- R1: After synchronous reset, `rdata_oe` is 0 and `rdata` is 0, and no access is open.
- R2: A controller-strobe start (`strb_ctl_n`=0, which wins over the host strobe) is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. A host-strobe start ignores `sel_c_n`. An unselected start closes the open access and acts as a deselect.
- R3: A selected host-strobe start is always a read, and it leaves the array unchanged even when write inputs are asserted.
- R4: Lane `i` is bits [9i+8:9i]. If `all_we_n`=0, all lanes are written. Otherwise, if `bytes_en_n`=0, only the lanes with `lane_we_n[i]`=0 are written. Otherwise the access is a read, and a byte write with no lane selected is also a read. Lanes that are not written keep their contents.
- R5: With `pipe_sel`=0, the data of a read sampled at edge N appears in the cycle after edge N. With `pipe_sel`=1, it appears after edge N+1.
- R6: A deselect, write or idle sampled at edge N leaves the bus driven with the last read data until edge N+1. The bus is undriven after edge N+1 in both modes.
- R7: While an access is open and no strobe is asserted, `adv_n`=0 runs an access at `addr`, decoded as in R4. `adv_n`=1 runs no access and the bus keeps its state and data. With no open access, a cycle without a strobe is a deselect.
- R8: `oe_n`=1 forces `rdata_oe`=0 and `rdata`=0 at once, and the read pipeline is unaffected.
- R9: `sleep`=1 forces `rdata_oe`=0 at once, blocks reads and writes, and closes the open access. The array keeps its contents, and the first edge after `sleep` falls is processed normally.
- R10: A read that is sampled on the edge right after a write to the same address returns the newly written lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_a_n | input | 1 | Chip enable A, active low |
| sel_b | input | 1 | Chip enable B, active high |
| sel_c_n | input | 1 | Chip enable C, active low, checked only on controller-strobe starts |
| strb_host_n | input | 1 | Host address strobe, active low, read-only start |
| strb_ctl_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Continue an open access, active low |
| addr | input | ADDR_W | Word address from the burst sequencer |
| lane_we_n | input | LANES | Per-lane write selects, active low |
| bytes_en_n | input | 1 | Lane-write enable, active low |
| all_we_n | input | 1 | Write every lane, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Low-power request, active high |
| pipe_sel | input | 1 | 1 selects registered reads, 0 selects flow-through |
| wdata | input | LANES*LANE_W | Write data |
| rdata | output | LANES*LANE_W | Read data, 0 when not driven |
| rdata_oe | output | 1 | Bus drive enable |

## Verification
The bench goes after the latency split: a design that applied the flow-through bypass to deselects as well would turn the bus off one cycle early in flow-through mode, and a design that delayed reads would return stale words. Partial lane masks, a byte write with no lane selected, and the global write overriding a disabled byte write each catch lane decoders that write too much or too little. The bench also checks that the third chip enable is ignored on host starts and that a host start with write inputs leaves the array alone; a wrong design would deselect those host starts or corrupt the stored word. Suspend cycles, and reads issued right after a write, show whether the held bus and the late array update line up. Sleep and output-enable pulses show whether gating the drivers leaks into the pipeline state.

// File: rtl/sbsram_pkg.sv
`timescale 1ns/1ps
package sbsram_pkg;

    localparam int DEF_ADDR_W = 6;
    localparam int DEF_LANES  = 2;
    localparam int DEF_LANE_W = 9;

    // Kind of work placed in the access stage on each edge.
    typedef enum logic [1:0] {
        TK_OFF  = 2'd0,   // deselect, write, idle or sleep: bus goes off
        TK_RD   = 2'd1,   // read: bus carries the array word
        TK_KEEP = 2'd2    // suspend: bus keeps its state
    } tok_e;

    typedef struct packed {
        tok_e tok;
        logic open;
    } step_t;

    // Chip selection; the third enable only counts when need_c is set.
    function automatic logic chip_on(logic need_c, logic a_n, logic b, logic c_n);
        return !a_n && b && (!need_c || !c_n);
    endfunction

endpackage

// File: rtl/sbsram_decode.sv
`timescale 1ns/1ps
module sbsram_decode
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int LANES  = DEF_LANES,
    parameter int LANE_W = DEF_LANE_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sel_a_n,
    input  logic                    sel_b,
    input  logic                    sel_c_n,
    input  logic                    strb_host_n,
    input  logic                    strb_ctl_n,
    input  logic                    adv_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES-1:0]        lane_we_n,
    input  logic                    bytes_en_n,
    input  logic                    all_we_n,
    input  logic                    sleep,
    input  logic [LANES*LANE_W-1:0] wdata,
    output tok_e                    tok_q,
    output logic [ADDR_W-1:0]       addr_q,
    output logic [LANES-1:0]        wmask_q,
    output logic [LANES*LANE_W-1:0] wdata_q
);
    localparam int DW = LANES * LANE_W;

    logic             open_q;
    logic [LANES-1:0] req_mask;
    logic [LANES-1:0] mask_d;
    step_t            nxt;
    logic             ctl_start;
    logic             host_start;

    // Per-lane write request.
    for (genvar g = 0; g < LANES; g++) begin : g_lane_req
        assign req_mask[g] = !all_we_n || (!bytes_en_n && !lane_we_n[g]);
    end

    assign ctl_start  = !strb_ctl_n;
    assign host_start = !strb_host_n && strb_ctl_n;

    always_comb begin
        nxt.tok  = TK_OFF;
        nxt.open = open_q;
        mask_d   = '0;
        if (sleep) begin
            nxt.open = 1'b0;
        end else if (ctl_start) begin
            nxt.open = chip_on(1'b1, sel_a_n, sel_b, sel_c_n);
            if (nxt.open) begin
                if (|req_mask) mask_d = req_mask;
                else           nxt.tok = TK_RD;
            end
        end else if (host_start) begin
            nxt.open = chip_on(1'b0, sel_a_n, sel_b, sel_c_n);
            if (nxt.open) nxt.tok = TK_RD;
        end else if (open_q) begin
            if (!adv_n) begin
                if (|req_mask) mask_d = req_mask;
                else           nxt.tok = TK_RD;
            end else begin
                nxt.tok = TK_KEEP;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tok_q   <= TK_OFF;
            open_q  <= 1'b0;
            wmask_q <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            tok_q   <= nxt.tok;
            open_q  <= nxt.open;
            wmask_q <= mask_d;
            addr_q  <= addr;
            wdata_q <= wdata;
        end
    end

    // R2: controller start with chip enable C inactive is a deselect
    p_ctl_needs_c_r2: assert property (@(posedge clk) disable iff (rst)
        (!sleep && !strb_ctl_n && sel_c_n) |=> (tok_q == TK_OFF && wmask_q == '0));

    // R3: selected host start reads and never writes
    p_host_reads_r3: assert property (@(posedge clk) disable iff (rst)
        (!sleep && strb_ctl_n && !strb_host_n && !sel_a_n && sel_b)
        |=> (tok_q == TK_RD && wmask_q == '0));

    // R9: sleep blocks every access
    p_sleep_blocks_r9: assert property (@(posedge clk) disable iff (rst)
        sleep |=> (tok_q == TK_OFF && wmask_q == '0));

    logic [DW-1:0] unused_w;
    assign unused_w = '0;
endmodule

// File: rtl/sbsram_array.sv
`timescale 1ns/1ps
module sbsram_array
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int LANES  = DEF_LANES,
    parameter int LANE_W = DEF_LANE_W
) (
    input  logic                    clk,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES-1:0]        wmask,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int DW    = LANES * LANE_W;

    logic [DW-1:0] mem [DEPTH];

    // Late write: the captured access is committed on the following edge.
    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES; i++) begin
            if (wmask[i]) mem[addr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
        end
    end

    assign rd_data = mem[addr];
endmodule

// File: rtl/sbsram_outpath.sv
`timescale 1ns/1ps
module sbsram_outpath
    import sbsram_pkg::*;
#(
    parameter int DW = DEF_LANES * DEF_LANE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pipe_sel,
    input  logic          oe_n,
    input  logic          sleep,
    input  tok_e          tok_a,
    input  logic [DW-1:0] arr_data,
    output logic          rdata_oe,
    output logic [DW-1:0] rdata
);
    logic          en_b;
    logic [DW-1:0] data_b;
    logic          flow_hit;
    logic          en_raw;
    logic [DW-1:0] val;

    // Output stage, shared by both modes: carries reads and the delayed off.
    always_ff @(posedge clk) begin
        if (rst) begin
            en_b   <= 1'b0;
            data_b <= '0;
        end else begin
            unique case (tok_a)
                TK_RD: begin
                    en_b   <= 1'b1;
                    data_b <= arr_data;
                end
                TK_OFF:  en_b <= 1'b0;
                default: ;
            endcase
        end
    end

    assign flow_hit = !pipe_sel && (tok_a == TK_RD);
    assign en_raw   = flow_hit || en_b;
    assign val      = flow_hit ? arr_data : data_b;
    assign rdata_oe = en_raw && !oe_n && !sleep;
    assign rdata    = rdata_oe ? val : '0;

    // R8/R9: asynchronous gates keep the bus undriven
    p_gate_off_r8: assert property (@(posedge clk) disable iff (rst)
        (oe_n || sleep) |-> (!rdata_oe && rdata == '0));

    // R6: two non-read steps in a row leave the bus off
    p_dcd_off_r6: assert property (@(posedge clk) disable iff (rst)
        (tok_a != TK_RD && $past(tok_a) == TK_OFF) |-> !rdata_oe);

    // R7: a suspend step keeps the output stage
    p_suspend_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (tok_a == TK_KEEP) |=> ($stable(en_b) && $stable(data_b)));
endmodule

// File: rtl/sbsram_core.sv
`timescale 1ns/1ps
module sbsram_core
    import sbsram_pkg::*;
#(
    parameter int ADDR_W = DEF_ADDR_W,
    parameter int LANES  = DEF_LANES,
    parameter int LANE_W = DEF_LANE_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sel_a_n,
    input  logic                    sel_b,
    input  logic                    sel_c_n,
    input  logic                    strb_host_n,
    input  logic                    strb_ctl_n,
    input  logic                    adv_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES-1:0]        lane_we_n,
    input  logic                    bytes_en_n,
    input  logic                    all_we_n,
    input  logic                    oe_n,
    input  logic                    sleep,
    input  logic                    pipe_sel,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata,
    output logic                    rdata_oe
);
    localparam int DW = LANES * LANE_W;

    tok_e              tok_a;
    logic [ADDR_W-1:0] addr_a;
    logic [LANES-1:0]  wmask_a;
    logic [DW-1:0]     wdata_a;
    logic [DW-1:0]     arr_data;

    sbsram_decode #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_decode (
        .clk(clk), .rst(rst),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .strb_host_n(strb_host_n), .strb_ctl_n(strb_ctl_n), .adv_n(adv_n),
        .addr(addr), .lane_we_n(lane_we_n), .bytes_en_n(bytes_en_n),
        .all_we_n(all_we_n), .sleep(sleep), .wdata(wdata),
        .tok_q(tok_a), .addr_q(addr_a), .wmask_q(wmask_a), .wdata_q(wdata_a)
    );

    sbsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk(clk), .addr(addr_a), .wmask(wmask_a), .wdata(wdata_a),
        .rd_data(arr_data)
    );

    sbsram_outpath #(.DW(DW)) u_out (
        .clk(clk), .rst(rst), .pipe_sel(pipe_sel), .oe_n(oe_n), .sleep(sleep),
        .tok_a(tok_a), .arr_data(arr_data),
        .rdata_oe(rdata_oe), .rdata(rdata)
    );
endmodule

// File: tb/sbsram_core_tb.sv
`timescale 1ns/1ps
module sbsram_core_tb_top;
    localparam int AW = 6;
    localparam int NW = 1 << AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sel_a_n, sel_b, sel_c_n, strb_host_n, strb_ctl_n, adv_n;
    logic [AW-1:0] addr;
    logic [1:0] lane_we_n;
    logic bytes_en_n, all_we_n, oe_n, sleep, pipe_sel;
    logic [17:0] wdata;
    logic [17:0] rdata;
    logic rdata_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    string req = "R1";

    // Reference model state
    logic [17:0] mm [NW];
    int          hk[$];   // 0 off, 1 read, 2 keep
    logic [17:0] hv[$];
    bit          m_open;

    always #5 clk = ~clk;

    sbsram_core dut_i (
        .clk(clk), .rst(rst), .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .strb_host_n(strb_host_n), .strb_ctl_n(strb_ctl_n), .adv_n(adv_n),
        .addr(addr), .lane_we_n(lane_we_n), .bytes_en_n(bytes_en_n),
        .all_we_n(all_we_n), .oe_n(oe_n), .sleep(sleep), .pipe_sel(pipe_sel),
        .wdata(wdata), .rdata(rdata), .rdata_oe(rdata_oe)
    );

    task automatic set_idle();
        sel_a_n = 0; sel_b = 1; sel_c_n = 0;
        strb_host_n = 1; strb_ctl_n = 1; adv_n = 1;
        lane_we_n = 2'b11; bytes_en_n = 1; all_we_n = 1;
        wdata = '0;
    endtask

    // Model of one edge, from the requirement text.
    task automatic model_edge();
        int kind = 0;
        logic [17:0] v = '0;
        bit acc = 0;
        logic [1:0] m;
        if (sleep) m_open = 0;
        else if (!strb_ctl_n) begin
            m_open = (!sel_a_n && sel_b && !sel_c_n);
            acc = m_open;
        end else if (!strb_host_n) begin
            m_open = (!sel_a_n && sel_b);
            if (m_open) begin kind = 1; v = mm[addr]; end
        end else if (m_open) begin
            if (!adv_n) acc = 1; else kind = 2;
        end
        if (acc) begin
            m = !all_we_n ? 2'b11 : (!bytes_en_n ? ~lane_we_n : 2'b00);
            if (m == 2'b00) begin kind = 1; v = mm[addr]; end
            else begin
                if (m[0]) mm[addr][8:0]  = wdata[8:0];
                if (m[1]) mm[addr][17:9] = wdata[17:9];
            end
        end
        hk.push_back(kind);
        hv.push_back(v);
    endtask

    function automatic void view(int k, output bit on, output logic [17:0] v);
        on = 0; v = '0;
        while (k >= 0 && hk[k] == 2) k--;
        if (k >= 0 && hk[k] == 1) begin on = 1; v = hv[k]; end
    endfunction

    task automatic compare();
        bit on; logic [17:0] v;
        bit e_oe; logic [17:0] e_d;
        int t = hk.size() - 1;
        if (!pipe_sel && t >= 0 && hk[t] == 1) begin on = 1; v = hv[t]; end
        else view(t - 1, on, v);
        e_oe = on && !oe_n && !sleep;
        e_d  = e_oe ? v : '0;
        n_chk++;
        if (rdata_oe !== e_oe || rdata !== e_d) begin
            n_bad++;
            $display("FAIL %s: oe=%0b data=%h expected oe=%0b data=%h",
                     req, rdata_oe, rdata, e_oe, e_d);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        #1;
        compare();
    endtask

    task automatic op_wr(int a, logic [1:0] lanes, bit glob, logic [17:0] d);
        set_idle(); strb_ctl_n = 0; addr = a[AW-1:0]; wdata = d;
        if (glob) all_we_n = 0; else begin bytes_en_n = 0; lane_we_n = ~lanes; end
        tick();
    endtask
    task automatic op_rd(int a);
        set_idle(); strb_ctl_n = 0; addr = a[AW-1:0]; tick();
    endtask
    task automatic op_rdh(int a);
        set_idle(); strb_host_n = 0; addr = a[AW-1:0]; tick();
    endtask
    task automatic op_cont(int a);
        set_idle(); adv_n = 0; addr = a[AW-1:0]; tick();
    endtask
    task automatic op_idle();
        set_idle(); tick();
    endtask

    task automatic suite();
        req = "R5";
        op_rd(1); op_rd(2); op_rd(3); op_idle();
        req = "R6";
        op_rd(4); op_idle(); op_idle(); op_rd(5); op_wr(6, 2'b11, 0, 18'h2aaaa); op_idle();
        req = "R4";
        op_wr(7, 2'b01, 0, 18'h3ffff); op_rd(7);
        op_wr(8, 2'b10, 0, 18'h00000); op_rd(8);
        set_idle(); strb_ctl_n = 0; addr = 9; bytes_en_n = 0; wdata = 18'h12345; tick();
        op_rd(9);
        set_idle(); strb_ctl_n = 0; addr = 10; all_we_n = 0; bytes_en_n = 1; wdata = 18'h0f0f0; tick();
        op_rd(10); op_idle();
        req = "R10";
        op_wr(11, 2'b11, 1, 18'h15a5a); op_rd(11);
        op_wr(11, 2'b10, 0, 18'h00c3c); op_rd(11); op_idle();
        req = "R2";
        set_idle(); strb_ctl_n = 0; sel_c_n = 1; addr = 12; tick();
        set_idle(); strb_host_n = 0; sel_c_n = 1; addr = 13; tick();
        set_idle(); strb_ctl_n = 0; sel_a_n = 1; addr = 14; tick();
        set_idle(); strb_host_n = 0; sel_b = 0; addr = 15; tick();
        set_idle(); strb_host_n = 0; strb_ctl_n = 0; sel_c_n = 1; addr = 16; tick();
        op_idle(); op_idle();
        req = "R3";
        set_idle(); strb_host_n = 0; all_we_n = 0; addr = 17; wdata = 18'h11111; tick();
        op_rd(17); op_idle();
        req = "R7";
        op_rd(20); op_cont(21); op_idle(); op_idle(); op_cont(22);
        set_idle(); adv_n = 0; addr = 23; bytes_en_n = 0; lane_we_n = 2'b01; wdata = 18'h3c3c3; tick();
        op_cont(23);
        set_idle(); strb_ctl_n = 0; sel_a_n = 1; tick();
        op_cont(24); op_cont(25); op_idle();
        req = "R8";
        op_rd(26); oe_n = 1; op_rd(27); op_idle(); oe_n = 0; op_idle(); op_idle();
        op_rd(28); op_cont(29); oe_n = 1; op_idle(); oe_n = 0; op_idle(); op_idle();
        req = "R9";
        op_rd(30); sleep = 1; op_wr(30, 2'b11, 1, 18'h00001); op_cont(31);
        sleep = 0; op_cont(31); op_rd(30); op_idle(); op_idle();
    endtask

    initial begin
        #1_000_000;
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        set_idle(); addr = '0; oe_n = 0; sleep = 0; pipe_sel = 0; m_open = 0;
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 0; #1;
        req = "R1";
        n_chk++;
        if (rdata_oe !== 1'b0 || rdata !== 18'h0) begin
            n_bad++;
            $display("FAIL R1: oe=%0b data=%h expected oe=0 data=00000", rdata_oe, rdata);
        end
        op_idle();
        req = "R4";
        for (int a = 0; a < NW; a++) op_wr(a, 2'b11, 1, 18'((a * 1237 + 91) & 18'h3ffff));
        op_idle();
        pipe_sel = 0; suite();
        pipe_sel = 1; op_idle(); op_idle(); suite();
        req = "R7";
        for (int n = 0; n < 3000; n++) begin
            int r = $urandom_range(0, 99);
            if (n % 500 == 0) pipe_sel = ~pipe_sel;
            set_idle();
            addr = AW'($urandom_range(0, NW - 1));
            wdata = 18'($urandom);
            if (r < 30) strb_ctl_n = 0;
            else if (r < 40) strb_host_n = 0;
            else if (r < 80) adv_n = 0;
            if ($urandom_range(0, 9) < 3) all_we_n = $urandom_range(0, 3) != 0;
            if ($urandom_range(0, 9) < 4) begin bytes_en_n = 0; lane_we_n = 2'($urandom); end
            if ($urandom_range(0, 19) == 0) sel_c_n = 1;
            if ($urandom_range(0, 29) == 0) sel_a_n = 1;
            oe_n  = ($urandom_range(0, 9) == 0);
            sleep = ($urandom_range(0, 19) == 0);
            tick();
        end
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule